// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This stage sits in a video pipeline just ahead of the DAC. It lays a small two-colour cursor image over the outgoing pixel stream. Each cycle it receives the current scan coordinates and the incoming 24-bit pixel. It decides whether that coordinate falls inside the 64x64 cursor window. On a hit it reads one word of the cursor bitmap from a video-memory read port. One cycle later it emits one of four things: the incoming pixel, its bitwise inverse, the expanded background colour or the expanded foreground colour.

Software programs six values through a simple write port:
- an overlay enable;
- two compact 8-bit colours in 3:3:2 form;
- a bitmap base in kilobyte units;
- an unsigned screen position;
- a signed hotspot offset.

The offset is subtracted from the position. This lets the cursor image hang past the top and left edges of the screen even though the position itself can never go negative.

Top module: `curs_overlay`

## Requirements
- R1: While reset is held, every register clears: the overlay is off, `memRd` is low and `pixOut` is zero. After reset, the output is the input pixel until software enables the overlay.
- R2: Bit 0 of the byte written at address 0x140 enables the overlay. While it is 0, `memRd` stays low and `pixOut` equals the `pixIn` of the previous cycle.
- R3: The byte at 0x141 holds the foreground colour and the byte at 0x142 holds the background colour. Both are coded red [7:5], green [4:2], blue [1:0]. Each channel expands to 8 bits by repeating its bits from the top: 3-bit {a,a,a[2:1]}, 2-bit {b,b,b,b}. The output is packed red [23:16], green [15:8], blue [7:0].
- R4: The value at 0x144 (bits 11:0) is the bitmap base in units of 1024 bytes. Whenever the scan point hits the cursor, `memRd` is high and `memAddr` = base*1024 + row*16 + (col/16)*4, where row and col are the coordinates inside the cursor image. Otherwise `memRd` is low.
- R5: The word at 0x148 holds the unsigned cursor position: X in bits 15:0 and Y in bits 31:16.
- R6: The 16-bit value at 0x14C holds a signed Y delta in bits 15:8 and a signed X delta in bits 7:0. The image's top-left corner sits at position minus delta. A scan point hits when it lies 0..63 columns right of and 0..63 rows below that corner. Because of this, a positive delta makes the image start above or left of the screen origin.
- R7: Each cursor pixel is a 2-bit code. Within the 32-bit memory word, column c uses bits [2*(c mod 16)+1 : 2*(c mod 16)]. The codes mean: 00 shows the input pixel, 01 shows its bitwise inverse, 10 shows the background colour and 11 shows the foreground colour.
- R8: Memory returns `memData` one cycle after the read. `pixOut` therefore belongs to the scan point and pixel presented in the previous cycle.
- R9: Writes to any address other than the six above change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 9 | Register byte address |
| regWdata | input | 32 | Register write data |
| scanX | input | COORD_W | Current scan column |
| scanY | input | COORD_W | Current scan line |
| pixIn | input | 24 | Incoming pixel, red/green/blue |
| memRd | output | 1 | Bitmap read request |
| memAddr | output | ADDR_W | Bitmap byte address |
| memData | input | 32 | Bitmap word, valid one cycle after `memRd` |
| pixOut | output | 24 | Outgoing pixel |

## Verification
The bench probes the four edges of the cursor window and the first pixel just outside each edge. An off-by-one hit test would show a cursor colour where the input pixel belongs, or the reverse. It also targets the lane boundary between columns 15 and 16, where a wrong word step or lane pick reads the wrong word or the wrong code. Positive and negative hotspot deltas check that the offset is subtracted with its sign; an unsigned or added delta moves the window. Unusual colour bytes and ignored register writes expose a misordered 3:3:2 expansion or a decode that aliases stray addresses.

// File: rtl/curs_pkg.sv
package curs_pkg;

  localparam int PIX_W      = 24;
  localparam int MEM_W      = 32;
  localparam int LANES      = MEM_W / 2;
  localparam int LANE_W     = $clog2(LANES);
  localparam int WORD_BYTES = MEM_W / 8;

  // Register byte addresses that software relies on.
  localparam logic [8:0] ADR_ENABLE = 9'h140;
  localparam logic [8:0] ADR_FGCOL  = 9'h141;
  localparam logic [8:0] ADR_BGCOL  = 9'h142;
  localparam logic [8:0] ADR_BASE   = 9'h144;
  localparam logic [8:0] ADR_POS    = 9'h148;
  localparam logic [8:0] ADR_DELTA  = 9'h14C;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic              hit;
    logic [LANE_W-1:0] lane;
  } ovlStrobe_t;

  // Widen a 3:3:2 colour byte to 8 bits per channel.
  function automatic logic [PIX_W-1:0] expand332(input logic [7:0] c);
    logic [7:0] r, g, b;
    r = {c[7:5], c[7:5], c[7:6]};
    g = {c[4:2], c[4:2], c[4:3]};
    b = {c[1:0], c[1:0], c[1:0], c[1:0]};
    return {r, g, b};
  endfunction

endpackage

// File: rtl/curs_ctrl.sv
module curs_ctrl
  import curs_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 22,
  parameter int CUR_DIM = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [8:0]         regAddr,
  input  logic [31:0]        regWdata,
  input  logic [COORD_W-1:0] scanX,
  input  logic [COORD_W-1:0] scanY,
  output logic               memRd,
  output logic [ADDR_W-1:0]  memAddr,
  output ovlStrobe_t         strobe,
  output logic [7:0]         fgCol,
  output logic [7:0]         bgCol
);

  localparam int DIM_W     = $clog2(CUR_DIM);
  localparam int ROW_BYTES = CUR_DIM * 2 / 8;
  localparam int BASE_W    = ADDR_W - 10;
  localparam int CW        = 18;

  logic              enReg;
  logic [BASE_W-1:0] baseReg;
  logic [15:0]       posX, posY;
  logic [7:0]        dX, dY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      fgCol   <= '0;
      bgCol   <= '0;
      baseReg <= '0;
      posX    <= '0;
      posY    <= '0;
      dX      <= '0;
      dY      <= '0;
    end else if (regWe) begin
      case (regAddr)
        ADR_ENABLE: enReg   <= regWdata[0];
        ADR_FGCOL:  fgCol   <= regWdata[7:0];
        ADR_BGCOL:  bgCol   <= regWdata[7:0];
        ADR_BASE:   baseReg <= regWdata[BASE_W-1:0];
        ADR_POS: begin
          posX <= regWdata[15:0];
          posY <= regWdata[31:16];
        end
        ADR_DELTA: begin
          dX <= regWdata[7:0];
          dY <= regWdata[15:8];
        end
        default: ;
      endcase
    end
  end

  // Offset of the scan point from the image corner (position - delta).
  logic [CW-1:0] relX, relY;
  logic          inX, inY, hit;
  logic [DIM_W-1:0] col, row;

  always_comb begin
    relX = CW'(scanX) - CW'(posX) + {{(CW-8){dX[7]}}, dX};
    relY = CW'(scanY) - CW'(posY) + {{(CW-8){dY[7]}}, dY};
    inX  = !relX[CW-1] && (relX < CW'(CUR_DIM));
    inY  = !relY[CW-1] && (relY < CW'(CUR_DIM));
    hit  = enReg && inX && inY;
    col  = relX[DIM_W-1:0];
    row  = relY[DIM_W-1:0];
  end

  assign memRd   = hit;
  assign memAddr = {baseReg, 10'd0}
                 + ADDR_W'(row) * ADDR_W'(ROW_BYTES)
                 + ADDR_W'(col >> LANE_W) * ADDR_W'(WORD_BYTES);

  assign strobe.hit  = hit;
  assign strobe.lane = col[LANE_W-1:0];

  p_off_no_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |-> !memRd);

  p_fetch_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr[ADDR_W-1:10] == baseReg));

  p_word_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr[1:0] == 2'b00));

endmodule

// File: rtl/curs_dpath.sv
module curs_dpath
  import curs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixIn,
  input  ovlStrobe_t       strobe,
  input  logic [7:0]       fgCol,
  input  logic [7:0]       bgCol,
  input  logic [MEM_W-1:0] memData,
  output logic [PIX_W-1:0] pixOut
);

  logic [PIX_W-1:0] pixD;
  ovlStrobe_t       strD;

  // Delay stage matching the one-cycle bitmap fetch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixD <= '0;
      strD <= '0;
    end else begin
      pixD <= pixIn;
      strD <= strobe;
    end
  end

  logic [1:0] laneCode [LANES];
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneCode[i] = memData[2*i+1 -: 2];
  end

  logic [1:0] code;
  assign code = laneCode[strD.lane];

  always_comb begin
    if (!strD.hit) pixOut = pixD;
    else begin
      case (code)
        2'b00:   pixOut = pixD;
        2'b01:   pixOut = ~pixD;
        2'b10:   pixOut = expand332(bgCol);
        default: pixOut = expand332(fgCol);
      endcase
    end
  end

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strD.hit |-> (pixOut == pixD));

  p_invert_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strD.hit && code == 2'b01) |-> (pixOut == ~pixD));

  p_fg_red_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strD.hit && code == 2'b11) |-> (pixOut[23:21] == fgCol[7:5]));

endmodule

// File: rtl/curs_overlay.sv
module curs_overlay
  import curs_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 22,
  parameter int CUR_DIM = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [8:0]         regAddr,
  input  logic [31:0]        regWdata,
  input  logic [COORD_W-1:0] scanX,
  input  logic [COORD_W-1:0] scanY,
  input  logic [23:0]        pixIn,
  output logic               memRd,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [31:0]        memData,
  output logic [23:0]        pixOut
);

  ovlStrobe_t strobe;
  logic [7:0] fgCol, bgCol;

  curs_ctrl #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .CUR_DIM(CUR_DIM)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .scanX(scanX), .scanY(scanY), .memRd(memRd),
    .memAddr(memAddr), .strobe(strobe), .fgCol(fgCol), .bgCol(bgCol)
  );

  curs_dpath u_dpath (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .strobe(strobe),
    .fgCol(fgCol), .bgCol(bgCol), .memData(memData), .pixOut(pixOut)
  );

endmodule

// File: tb/curs_overlay_tb.sv
module curs_overlay_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [11:0] scanX = '0, scanY = '0;
  logic [23:0] pixIn = '0;
  logic        memRd;
  logic [21:0] memAddr;
  logic [31:0] memData = '0;
  logic [23:0] pixOut;
  logic [31:0] tbPat = '0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  curs_overlay u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .scanX(scanX), .scanY(scanY), .pixIn(pixIn),
    .memRd(memRd), .memAddr(memAddr), .memData(memData), .pixOut(pixOut)
  );

  // Bitmap memory model: one-cycle read latency, returns the test word.
  always @(posedge clk) memData <= memRd ? tbPat : 32'h0;

  typedef struct packed {
    logic [31:0] pat;
    logic [11:0] x;
    logic [11:0] y;
    logic [23:0] pix;
    logic        rd;
    logic [21:0] addr;
    logic [23:0] exp;
  } vec_t;

  // Setup: base 3, position (100,50), delta 0, fg 0xE0, bg 0x1F.
  localparam vec_t VECS [13] = '{
    '{32'hFFFFFFFF, 12'd100, 12'd50,  24'h123456, 1'b1, 22'hC00, 24'hFF0000},
    '{32'hAAAAAAAA, 12'd163, 12'd113, 24'h123456, 1'b1, 22'hFFC, 24'h00FFFF},
    '{32'h55555555, 12'd110, 12'd60,  24'h123456, 1'b1, 22'hCA0, 24'hEDCBA9},
    '{32'h00000000, 12'd100, 12'd50,  24'h123456, 1'b1, 22'hC00, 24'h123456},
    '{32'hFFFFFFFF, 12'd99,  12'd50,  24'h0A0B0C, 1'b0, 22'h0,   24'h0A0B0C},
    '{32'hFFFFFFFF, 12'd164, 12'd50,  24'h0A0B0C, 1'b0, 22'h0,   24'h0A0B0C},
    '{32'hFFFFFFFF, 12'd100, 12'd49,  24'h0A0B0C, 1'b0, 22'h0,   24'h0A0B0C},
    '{32'hFFFFFFFF, 12'd100, 12'd114, 24'h0A0B0C, 1'b0, 22'h0,   24'h0A0B0C},
    '{32'h0000000C, 12'd101, 12'd50,  24'h123456, 1'b1, 22'hC00, 24'hFF0000},
    '{32'h0000000C, 12'd100, 12'd50,  24'h123456, 1'b1, 22'hC00, 24'h123456},
    '{32'h80000000, 12'd115, 12'd50,  24'h123456, 1'b1, 22'hC00, 24'h00FFFF},
    '{32'h80000000, 12'd116, 12'd50,  24'h123456, 1'b1, 22'hC04, 24'h123456},
    '{32'hAAAAAAAA, 12'd100, 12'd51,  24'h123456, 1'b1, 22'hC10, 24'h00FFFF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // Present one scan point; check the fetch in the same cycle and the
  // pixel one cycle later (R8).
  task automatic probe(input logic [11:0] x, input logic [11:0] y,
                       input logic [23:0] pix, input logic [31:0] pat,
                       input logic rd, input logic [21:0] addr,
                       input logic [23:0] exp, input string req);
    @(negedge clk);
    scanX = x; scanY = y; pixIn = pix; tbPat = pat;
    #1;
    chk(memRd == rd, {req, " memRd"}, {31'd0, memRd}, {31'd0, rd});
    if (rd) chk(memAddr == addr, {req, " memAddr"}, {10'd0, memAddr}, {10'd0, addr});
    @(posedge clk);
    #1;
    chk(pixOut == exp, {req, " pixOut"}, {8'd0, pixOut}, {8'd0, exp});
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pixIn = 24'h112233;
    repeat (3) @(posedge clk);
    #1;
    chk(pixOut == 24'h0 && !memRd, "R1 reset state", {8'd0, pixOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    // R1/R2: overlay off after reset passes the pixel through.
    probe(12'd0, 12'd0, 24'h445566, 32'hFFFFFFFF, 1'b0, '0, 24'h445566, "R1");

    wr(9'h141, 32'hE0);
    wr(9'h142, 32'h1F);
    wr(9'h144, 32'd3);
    wr(9'h148, {16'd50, 16'd100});   // R5: Y high half, X low half
    wr(9'h14C, 32'h0);
    wr(9'h140, 32'h1);

    // Table walk: R4 addressing, R7 codes and lanes, R6 window edges, R8.
    foreach (VECS[i])
      probe(VECS[i].x, VECS[i].y, VECS[i].pix, VECS[i].pat, VECS[i].rd,
            VECS[i].addr, VECS[i].exp, $sformatf("R7 vec%0d", i));

    // R6: positive delta pushes the image past the top-left corner.
    wr(9'h148, 32'h0);
    wr(9'h14C, 32'h050A);
    probe(12'd0,  12'd0,  24'h123456, 32'h00300000, 1'b1, 22'hC50, 24'hFF0000, "R6 corner");
    probe(12'd54, 12'd0,  24'h123456, 32'hFFFFFFFF, 1'b0, '0,      24'h123456, "R6 right edge");
    probe(12'd53, 12'd58, 24'h123456, 32'hFFFFFFFF, 1'b1, 22'hFFC, 24'hFF0000, "R6 last pixel");

    // R6: negative delta moves the image right and down.
    wr(9'h148, {16'd20, 16'd20});
    wr(9'h14C, 32'hFEFC);
    probe(12'd23, 12'd22, 24'h123456, 32'h3, 1'b0, '0,      24'h123456, "R6 neg left");
    probe(12'd24, 12'd21, 24'h123456, 32'h3, 1'b0, '0,      24'h123456, "R6 neg top");
    probe(12'd24, 12'd22, 24'h123456, 32'h3, 1'b1, 22'hC00, 24'hFF0000, "R6 neg origin");

    // R9: stray addresses are ignored.
    wr(9'h143, 32'h0);
    wr(9'h150, 32'h0);
    wr(9'h000, 32'h0);
    probe(12'd24, 12'd22, 24'h123456, 32'h3, 1'b1, 22'hC00, 24'hFF0000, "R9 stray write");

    // R3: bit-replicating expansion of uneven colours.
    wr(9'h141, 32'h6D);
    probe(12'd24, 12'd22, 24'h123456, 32'h3, 1'b1, 22'hC00, 24'h6D6D55, "R3 fg expand");
    wr(9'h142, 32'h92);
    probe(12'd24, 12'd22, 24'h123456, 32'h2, 1'b1, 22'hC00, 24'h9292AA, "R3 bg expand");

    // R4: base in kilobyte units.
    wr(9'h144, 32'd5);
    probe(12'd25, 12'd23, 24'h123456, 32'hC, 1'b1, 22'h1410, 24'h6D6D55, "R4 base move");

    // R2: disabling stops fetches and restores the input pixel.
    wr(9'h140, 32'h0);
    probe(12'd24, 12'd22, 24'h778899, 32'h3, 1'b0, '0, 24'h778899, "R2 disabled");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule